// File: doc/BRIEF.md
# Card request completion tracker

This block sits beside a card host controller. It decides the cycle in which a card request is finished. Each cycle it sees two things: the raw status bits of the command and data path, and the receive interrupt of the host's internal DMA engine. While a request runs, it gathers the enabled status bits into a sticky summary and widens its interrupt mask when the request needs that. When the finishing rules are met, it raises a single-cycle finalize pulse. It also forwards card interrupts from SDIO cards on an output of their own, whether or not a request is running.

A request is armed with a one-cycle `req_start` pulse, which carries four hints: read, data phase present, response expected, and stop attached. From these hints the block picks the status bit that marks completion. For data reads it also arms a wait on the DMA receive interrupt. Status bit positions are fixed (LSB = 0): 0 response error, 1 command done, 2 data over, 3 auto-stop done, 4 response CRC, 5 data CRC, 6 response timeout, 7 data timeout, 8 FIFO run error, 9 start-bit error, 10 end-bit error, 11 SDIO card interrupt. The error group is bits 0 and 4 to 10, which is mask value 0x7F1.

Top module: `req_done_tracker`

## Requirements
- R1: While reset is held and on the first cycle after it, `finalize`, `card_irq`, `dma_ie`, `summary` and `mask` are all zero.
- R2: On the clock after an accepted `req_start`, `mask` equals the error group 0x7F1, OR the selected done bit, OR 0x800 if `sdio_en` is high. `dma_ie` is 1 exactly when both `req_read` and `req_data` were high.
- R3: While a request is active, `summary` accumulates `status & mask` by OR. Status bits that are outside the mask never enter `summary`.
- R4: The done bit is auto-stop done (bit 3) when data, response and stop are all hinted. It is data over (bit 2) when data and response are hinted but no stop. In every other case it is command done (bit 1).
- R5: If the accumulated summary holds response timeout (bit 6) but not command done (bit 1), no finalize is issued and bit 1 is added to `mask` on the next clock. A later command done then finalizes the request.
- R6: Otherwise, any error-group bit in the accumulated summary finalizes the request on the next clock, even while the DMA wait is armed.
- R7: For a data read, the done bit does not finalize until `dma_rx` has been seen, either in an earlier cycle or in the same cycle as the done bit.
- R8: `finalize` is high for exactly one cycle, one clock after the deciding status. In that cycle `summary` shows the final value, `dma_ie` is 0 and `mask` holds only the SDIO bit (if enabled). `summary` is zero on the following cycle.
- R9: `card_irq` is high one clock after any cycle in which `status[11]` and `sdio_en` are both high, whether or not a request is active. Otherwise it is low.
- R10: While no request is active, `status` does not change `summary` and does not raise `finalize`. A `req_start` that arrives while a request is active is ignored, and `mask` and `dma_ie` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_start | input | 1 | One-cycle request arm pulse |
| req_read | input | 1 | Request reads data from the card |
| req_data | input | 1 | Request has a data phase |
| req_resp | input | 1 | Request expects a response |
| req_stop | input | 1 | Request ends with an automatic stop |
| status | input | 12 | Raw status bits for this cycle |
| dma_rx | input | 1 | DMA receive interrupt |
| sdio_en | input | 1 | Enable card interrupt forwarding |
| finalize | output | 1 | Request finished, one-cycle pulse |
| mask | output | 12 | Current interrupt mask |
| summary | output | 12 | Sticky summary of masked status |
| card_irq | output | 1 | Card interrupt pulse |
| dma_ie | output | 1 | DMA receive interrupt enable |

## Verification
Two things can land in the same cycle, and the bench drives both. First, response timeout and command done can arrive together in the status of a data write. Command done is still masked off at that point, so the request must defer and extend its mask, and then finish only when a second command done arrives. Second, an SDIO card interrupt can coincide with the deciding status of a command. Both `finalize` and `card_irq` must then rise in the same cycle, and the summary must carry both bits. A behavioural model is compared on every clock, and directed checks pin the expected mask, summary and pulse values.

// File: rtl/rdt_pkg.sv
package rdt_pkg;
    localparam int STAT_W = 12;

    localparam int B_RESP_ERR  = 0;
    localparam int B_CMD_DONE  = 1;
    localparam int B_DATA_OVER = 2;
    localparam int B_STOP_DONE = 3;
    localparam int B_RESP_CRC  = 4;
    localparam int B_DATA_CRC  = 5;
    localparam int B_RESP_TO   = 6;
    localparam int B_DATA_TO   = 7;
    localparam int B_FIFO_RUN  = 8;
    localparam int B_START_BIT = 9;
    localparam int B_END_BIT   = 10;
    localparam int B_SDIO      = 11;

    typedef logic [STAT_W-1:0] stat_t;

    localparam stat_t ONE       = stat_t'(1);
    localparam stat_t SDIO_MASK = ONE << B_SDIO;
    localparam stat_t CMD_MASK  = ONE << B_CMD_DONE;
    localparam stat_t ERR_GROUP = (ONE << B_RESP_ERR) | (ONE << B_RESP_CRC)
                                | (ONE << B_DATA_CRC) | (ONE << B_RESP_TO)
                                | (ONE << B_DATA_TO)  | (ONE << B_FIFO_RUN)
                                | (ONE << B_START_BIT) | (ONE << B_END_BIT);

    typedef enum logic [1:0] {
        DONE_BY_CMD  = 2'd0,
        DONE_BY_DATA = 2'd1,
        DONE_BY_STOP = 2'd2
    } done_src_e;

    typedef struct packed {
        logic is_read;
        logic has_data;
        logic has_resp;
        logic has_stop;
    } req_hint_t;

    function automatic done_src_e pick_done(input req_hint_t h);
        if (h.has_data && h.has_resp && h.has_stop) return DONE_BY_STOP;
        if (h.has_data && h.has_resp)               return DONE_BY_DATA;
        return DONE_BY_CMD;
    endfunction

    function automatic stat_t done_bit(input done_src_e s);
        case (s)
            DONE_BY_STOP: return ONE << B_STOP_DONE;
            DONE_BY_DATA: return ONE << B_DATA_OVER;
            default:      return ONE << B_CMD_DONE;
        endcase
    endfunction
endpackage

// File: rtl/rdt_accum.sv
module rdt_accum
    import rdt_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clr,
    input  logic  en,
    input  stat_t masked,
    output stat_t summary,
    output stat_t sum_next
);
    assign sum_next = summary | (en ? masked : '0);

    always_ff @(posedge clk) begin
        if (rst || clr)
            summary <= '0;
        else if (en)
            summary <= sum_next;
    end
endmodule

// File: rtl/rdt_decide.sv
module rdt_decide
    import rdt_pkg::*;
(
    input  logic  active,
    input  stat_t sum_next,
    input  logic  wait_next,
    input  stat_t done_mask,
    output logic  defer,
    output logic  fin_now
);
    logic has_err;
    logic has_done;

    always_comb begin
        defer    = active && sum_next[B_RESP_TO] && !sum_next[B_CMD_DONE];
        has_err  = |(sum_next & ERR_GROUP);
        has_done = |(sum_next & done_mask);
        fin_now  = active && !defer && (has_err || (has_done && !wait_next));
    end
endmodule

// File: rtl/rdt_mask.sv
module rdt_mask
    import rdt_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  sdio_en,
    input  logic  start,
    input  stat_t start_done,
    input  logic  start_read,
    input  logic  active,
    input  logic  defer,
    input  logic  fin_now,
    output stat_t mask,
    output logic  dma_ie
);
    stat_t sdio_part;

    assign sdio_part = sdio_en ? SDIO_MASK : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask   <= '0;
            dma_ie <= 1'b0;
        end else if (start) begin
            mask   <= sdio_part | ERR_GROUP | start_done;
            dma_ie <= start_read;
        end else if (fin_now || !active) begin
            mask   <= sdio_part;
            dma_ie <= 1'b0;
        end else begin
            mask <= (mask & ~SDIO_MASK) | sdio_part | (defer ? CMD_MASK : '0);
        end
    end
endmodule

// File: rtl/req_done_tracker.sv
module req_done_tracker
    import rdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_start,
    input  logic              req_read,
    input  logic              req_data,
    input  logic              req_resp,
    input  logic              req_stop,
    input  logic [STAT_W-1:0] status,
    input  logic              dma_rx,
    input  logic              sdio_en,
    output logic              finalize,
    output logic [STAT_W-1:0] mask,
    output logic [STAT_W-1:0] summary,
    output logic              card_irq,
    output logic              dma_ie
);
    req_hint_t hint;
    done_src_e done_q;
    logic      active_q, wait_q, fin_q, card_q;
    logic      start_ok, wait_next, defer, fin_now;
    stat_t     sum_next, masked;

    assign hint      = '{is_read: req_read, has_data: req_data,
                         has_resp: req_resp, has_stop: req_stop};
    assign start_ok  = req_start && !active_q;
    assign wait_next = wait_q && !dma_rx;
    assign masked    = status & mask;

    rdt_accum accum_i (
        .clk(clk), .rst(rst), .clr(start_ok || fin_q), .en(active_q),
        .masked(masked), .summary(summary), .sum_next(sum_next)
    );

    rdt_decide decide_i (
        .active(active_q), .sum_next(sum_next), .wait_next(wait_next),
        .done_mask(done_bit(done_q)), .defer(defer), .fin_now(fin_now)
    );

    rdt_mask mask_i (
        .clk(clk), .rst(rst), .sdio_en(sdio_en), .start(start_ok),
        .start_done(done_bit(pick_done(hint))),
        .start_read(hint.is_read && hint.has_data),
        .active(active_q), .defer(defer), .fin_now(fin_now),
        .mask(mask), .dma_ie(dma_ie)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            wait_q   <= 1'b0;
            fin_q    <= 1'b0;
            card_q   <= 1'b0;
            done_q   <= DONE_BY_CMD;
        end else begin
            fin_q  <= fin_now;
            card_q <= status[B_SDIO] && sdio_en;
            if (start_ok) begin
                active_q <= 1'b1;
                wait_q   <= hint.is_read && hint.has_data;
                done_q   <= pick_done(hint);
            end else if (fin_now) begin
                active_q <= 1'b0;
                wait_q   <= 1'b0;
            end else if (active_q) begin
                wait_q <= wait_next;
            end
        end
    end

    assign finalize = fin_q;
    assign card_irq = card_q;
endmodule

// File: rtl/rdt_checker.sv
module rdt_checker
    import rdt_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input stat_t status,
    input logic  sdio_en,
    input logic  active,
    input stat_t mask,
    input stat_t summary,
    input logic  finalize,
    input logic  card_irq,
    input logic  dma_ie
);
    assert_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        finalize |=> !finalize);
    assert_release_R8: assert property (@(posedge clk) disable iff (rst)
        finalize |-> (!dma_ie && ((mask & ~SDIO_MASK) == '0)));
    assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
        finalize |=> (summary == '0));
    assert_card_R9: assert property (@(posedge clk) disable iff (rst)
        (status[B_SDIO] && sdio_en) |=> card_irq);
    assert_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !(status[B_SDIO] && sdio_en) |=> !card_irq);
    assert_arm_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(active) |-> ((mask & ERR_GROUP) == ERR_GROUP));
    assert_idle_R10: assert property (@(posedge clk) disable iff (rst)
        (!active && !finalize) |-> (summary == '0));
endmodule

bind req_done_tracker rdt_checker chk_i (
    .clk(clk), .rst(rst), .status(status), .sdio_en(sdio_en),
    .active(active_q), .mask(mask), .summary(summary),
    .finalize(finalize), .card_irq(card_irq), .dma_ie(dma_ie)
);

// File: tb/req_done_tracker_tb_top.sv
module req_done_tracker_tb_top;
    localparam logic [11:0] ERRS = 12'h7F1;
    localparam logic [11:0] CMD  = 12'h002;
    localparam logic [11:0] DOV  = 12'h004;
    localparam logic [11:0] ASD  = 12'h008;
    localparam logic [11:0] SDIO = 12'h800;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_start = 0, req_read = 0, req_data = 0, req_resp = 0, req_stop = 0;
    logic [11:0] status = '0;
    logic dma_rx = 0, sdio_en = 0;
    logic finalize, card_irq, dma_ie;
    logic [11:0] mask, summary;

    int checks = 0, fails = 0;
    bit done = 0;

    always #5 clk = ~clk;

    req_done_tracker dut_i (
        .clk(clk), .rst(rst), .req_start(req_start), .req_read(req_read),
        .req_data(req_data), .req_resp(req_resp), .req_stop(req_stop),
        .status(status), .dma_rx(dma_rx), .sdio_en(sdio_en),
        .finalize(finalize), .mask(mask), .summary(summary),
        .card_irq(card_irq), .dma_ie(dma_ie)
    );

    // behavioural reference
    bit m_act, m_wait, m_fin, m_card, m_dma;
    logic [11:0] m_mask, m_sum, m_done;

    always @(posedge clk) begin
        bit fin, dfr, w;
        logic [11:0] ns, sdm;
        fin = 0; dfr = 0; w = 0; ns = m_sum;
        sdm = sdio_en ? SDIO : 12'h000;
        if (rst) begin
            m_act = 0; m_wait = 0; m_fin = 0; m_card = 0; m_dma = 0;
            m_mask = 0; m_sum = 0; m_done = CMD;
        end else begin
            if (m_act) begin
                ns = m_sum | (status & m_mask);
                w  = m_wait && !dma_rx;
                if (ns[6] && !ns[1]) dfr = 1;
                else if ((ns & ERRS) != 0) fin = 1;
                else if (((ns & m_done) != 0) && !w) fin = 1;
                m_sum = ns;
            end else if (m_fin || req_start) m_sum = 0;
            m_card = status[11] && sdio_en;
            if (req_start && !m_act) begin
                if (req_data && req_resp && req_stop) m_done = ASD;
                else if (req_data && req_resp) m_done = DOV;
                else m_done = CMD;
                m_act = 1; m_wait = req_read && req_data; m_dma = m_wait;
                m_mask = sdm | ERRS | m_done;
            end else if (fin || !m_act) begin
                m_mask = sdm; m_dma = 0; m_act = 0; m_wait = 0;
            end else begin
                m_mask = (m_mask & ~SDIO) | sdm | (dfr ? CMD : 12'h000);
                m_wait = w;
            end
            m_fin = fin;
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R8 model finalize", finalize, m_fin);
            chk("R2 model mask", mask, m_mask);
            chk("R3 model summary", summary, m_sum);
            chk("R9 model card_irq", card_irq, m_card);
            chk("R7 model dma_ie", dma_ie, m_dma);
        end
    end

    task automatic tick();
        @(posedge clk); #1;
        req_start = 0; status = '0; dma_rx = 0;
    endtask

    task automatic start(bit rd, bit dt, bit rs, bit sp);
        req_start = 1; req_read = rd; req_data = dt; req_resp = rs; req_stop = sp;
        tick();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset finalize", finalize, 0);
        chk("R1 reset mask", mask, 0);
        chk("R1 reset summary", summary, 0);
        rst = 0;
        tick();
        chk("R1 after reset dma_ie", dma_ie, 0);
        chk("R1 after reset card_irq", card_irq, 0);

        // plain command with response
        start(0, 0, 1, 0);
        chk("R2 cmd mask", mask, 12'h7F3);
        chk("R2 cmd dma_ie", dma_ie, 0);
        status = CMD; tick();
        chk("R8 cmd finalize", finalize, 1);
        chk("R4 cmd summary", summary, CMD);
        chk("R8 mask released", mask, 0);
        tick();
        chk("R8 single pulse", finalize, 0);
        chk("R8 summary cleared", summary, 0);

        // read, done before DMA
        start(1, 1, 1, 0);
        chk("R2 read mask", mask, 12'h7F5);
        chk("R2 read dma_ie", dma_ie, 1);
        status = DOV; tick();
        chk("R7 hold for dma", finalize, 0);
        tick();
        chk("R7 still held", finalize, 0);
        dma_rx = 1; tick();
        chk("R7 dma releases", finalize, 1);
        chk("R8 dma_ie dropped", dma_ie, 0);
        tick();

        // read, DMA before done
        start(1, 1, 1, 0);
        dma_rx = 1; tick();
        chk("R7 early dma", finalize, 0);
        status = DOV; tick();
        chk("R7 done after dma", finalize, 1);
        tick();

        // write with stop: data over masked off
        start(0, 1, 1, 1);
        chk("R4 stop mask", mask, 12'h7F9);
        status = DOV; tick();
        chk("R3 masked bit ignored", summary, 0);
        chk("R4 data over not done", finalize, 0);
        status = ASD; tick();
        chk("R4 stop done finalizes", finalize, 1);
        chk("R4 stop summary", summary, ASD);
        tick();

        // timeout and command done together on a data write
        start(0, 1, 1, 0);
        status = 12'h042; tick();
        chk("R5 deferred", finalize, 0);
        chk("R5 mask widened", mask, 12'h7F7);
        chk("R5 summary", summary, 12'h040);
        status = CMD; tick();
        chk("R5 cmd done finalizes", finalize, 1);
        chk("R5 final summary", summary, 12'h042);
        tick();

        // error during DMA wait
        start(1, 1, 1, 0);
        status = 12'h020; tick();
        chk("R6 error bypasses wait", finalize, 1);
        chk("R6 summary", summary, 12'h020);
        tick();

        // card interrupts
        sdio_en = 1; tick();
        chk("R9 idle mask", mask, SDIO);
        status = SDIO; tick();
        chk("R9 idle card pulse", card_irq, 1);
        chk("R10 idle summary", summary, 0);
        sdio_en = 0; status = SDIO; tick();
        chk("R9 gated off", card_irq, 0);

        // idle status ignored, restart ignored
        status = CMD; tick();
        chk("R10 idle no finalize", finalize, 0);
        chk("R10 idle no summary", summary, 0);
        start(1, 1, 1, 0);
        start(0, 0, 1, 0);
        chk("R10 restart mask", mask, 12'h7F5);
        chk("R10 restart dma_ie", dma_ie, 1);
        status = 12'h001; tick();
        chk("R6 resp error", finalize, 1);
        tick();

        // card interrupt with finalize
        sdio_en = 1;
        start(0, 0, 1, 0);
        chk("R2 mask with sdio", mask, 12'hFF3);
        status = 12'h802; tick();
        chk("R8 finalize with card", finalize, 1);
        chk("R9 card with finalize", card_irq, 1);
        chk("R3 both bits", summary, 12'h802);
        chk("R8 sdio mask kept", mask, SDIO);
        tick(); tick();

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL R8 watchdog expired actual=hung expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule